// File: doc/BRIEF.md
# Indexed Effective Address Sequencer

This block forms the 16-bit effective address for the indexed addressing mode of an 8-bit processor. A single postbyte names a base pointer (X, Y, U or S) and an addressing form. The forms are a short signed offset inside the postbyte, automatic stepping of the pointer, an offset from an accumulator, a constant offset taken from the instruction stream, an offset from the program counter, and an absolute address that is always dereferenced. Most forms can also take one level of memory indirection, in which the computed address points at a two-byte pointer that becomes the result.

The surrounding core pulses `start_i` with the postbyte, a snapshot of the registers and the program counter, which points just past the postbyte. The sequencer then pulls offset bytes and indirect pointer bytes through a byte-wide read port with a valid/ready handshake. It issues no more than one read per cycle. It finishes with a one-cycle `done_o` that carries the address, the write-backs of the stepped pointer and the advanced program counter, and an optional load-effective-address write into a chosen pointer. A postbyte with no meaning ends the operation at once with `illegal_o` and with every write-back held low.

Top module: `idx_ea_seq`

## Requirements
- R1: Postbyte bits 6:5 pick the base pointer: 00 X, 01 Y, 10 U, 11 S. The stepped-pointer write-back names the same pointer on `ptr_sel_o`, using that encoding.
- R2: With postbyte bit 7 at 0, bits 4:0 form a two's-complement offset with bit 4 as its sign. The address is the base plus that offset, sign-extended. No reads are made, and `done_o` rises two cycles after `start_i` is taken.
- R3: With bit 7 at 1, low nibble 0 and 1 use the unchanged base as the address and write back base+1 and base+2. Nibbles 2 and 3 use base-1 and base-2 as the address and write that same value back. `ptr_we_o` is high only for these four nibbles.
- R4: Nibble 4 uses the base alone. Nibble 5 adds B and nibble 6 adds A, each sign-extended. Nibble B adds the 16-bit value with A as the high byte and B as the low byte.
- R5: Nibble 8 reads one offset byte at the program counter and sign-extends it. Nibble 9 reads two bytes, high first. Each byte read advances the program counter by one, and `pc_o` returns the advanced value on a legal `done_o`.
- R6: Nibbles C and D are like 8 and 9, but the base is the program counter after the offset bytes, not the postbyte pointer.
- R7: With bit 4 set alongside bit 7, the computed address is read as a pointer, high byte at the address and low byte at the address plus one. The result is that pointer.
- R8: Nibble F with bit 4 set and bits 6:5 at 00 reads a two-byte absolute address at the program counter, high byte first, advances the program counter by 2, and then dereferences that address as in R7.
- R9: Nibbles 7, A and E, nibbles 0 and 2 with bit 4 set, and nibble F in any other form are illegal. Each raises `illegal_o` and `done_o` together two cycles after start, makes no read, and holds `ptr_we_o`, `pc_we_o` and `lea_we_o` low.
- R10: A read holds its address while `mem_ready_i` is low. With ready held high, done comes after 2 cycles, plus one cycle per offset byte, plus one cycle when offset bytes were read, plus two cycles for indirection.
- R11: When `lea_en_i` was high at start, a legal done also raises `lea_we_o`, with `lea_sel_o` equal to `lea_dst_i` as it was at start, using the R1 encoding.
- R12: `done_o` lasts one cycle, and every write-back strobe is high only together with `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin an address computation (taken while idle) |
| postbyte_i | input | 8 | Indexed postbyte |
| lea_en_i | input | 1 | Request a load-effective-address write-back |
| lea_dst_i | input | 2 | Destination pointer for that write-back |
| ptr_x_i | input | 16 | Pointer X |
| ptr_y_i | input | 16 | Pointer Y |
| ptr_u_i | input | 16 | Pointer U |
| ptr_s_i | input | 16 | Pointer S |
| pc_i | input | 16 | Program counter, pointing past the postbyte |
| acc_a_i | input | 8 | Accumulator A |
| acc_b_i | input | 8 | Accumulator B |
| mem_req_o | output | 1 | Read request valid |
| mem_addr_o | output | 16 | Read address |
| mem_ready_i | input | 1 | Read accepted, data valid this cycle |
| mem_rdata_i | input | 8 | Read data |
| ea_o | output | 16 | Effective address, valid with done |
| done_o | output | 1 | Operation finished |
| illegal_o | output | 1 | Postbyte was illegal |
| ptr_we_o | output | 1 | Stepped-pointer write-back strobe |
| ptr_sel_o | output | 2 | Pointer being stepped |
| ptr_wdata_o | output | 16 | Stepped pointer value |
| pc_we_o | output | 1 | Program counter write-back strobe |
| pc_o | output | 16 | Advanced program counter |
| lea_we_o | output | 1 | Effective-address write-back strobe |
| lea_sel_o | output | 2 | Pointer receiving the effective address |

## Verification
The bench runs every one of the 256 postbytes against two register snapshots and checks each against an arithmetic model. The first snapshot has positive accumulators. The second has negative accumulators and a program counter near the top of memory, so sign extension and wrap-around are tested. A design that zero-extends a short, accumulator or 8-bit offset would land 256 or 32 bytes off. One that took the PC-relative base before the offset was consumed would be off by the offset length. One that swaps the pointer bytes in indirection would return a byte-swapped address.

The illegal combinations are checked with a count of reads and with the write strobes. A decoder that accepts nibble F with a non-zero pointer field, or indirect single stepping, would show reads and a pc write where none may occur. A stall pattern on ready shows whether a design that counts bytes by cycles, rather than by accepted transfers, loses or repeats bytes.

// File: rtl/idx_ea_pkg.sv
package idx_ea_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned ADDR_W  = 2 * BYTE_W;
  localparam int unsigned PSEL_W  = 2;
  localparam int unsigned SHORT_W = 5;
  localparam int unsigned CNT_W   = 2;

  typedef enum logic [3:0] {
    MD_SHORT, MD_INC1, MD_INC2, MD_DEC1, MD_DEC2, MD_ZERO, MD_ACC_B,
    MD_ACC_A, MD_ACC_D, MD_CONST8, MD_CONST16, MD_PCREL8, MD_PCREL16,
    MD_EXTIND
  } idx_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DECODE, ST_FETCH, ST_ADDR, ST_IND_HI, ST_IND_LO, ST_FIN
  } idx_state_e;

  typedef struct packed {
    logic             illegal;
    logic             indirect;
    logic             autostep;
    idx_mode_e        mode;
    logic [CNT_W-1:0] nofs;
  } idx_decode_t;

  function automatic logic [ADDR_W-1:0] sext_byte(input logic [BYTE_W-1:0] v);
    return {{(ADDR_W-BYTE_W){v[BYTE_W-1]}}, v};
  endfunction

  function automatic logic [ADDR_W-1:0] sext_short(input logic [SHORT_W-1:0] v);
    return {{(ADDR_W-SHORT_W){v[SHORT_W-1]}}, v};
  endfunction
endpackage

// File: rtl/idx_postbyte_decode.sv
module idx_postbyte_decode
  import idx_ea_pkg::*;
(
  input  logic [BYTE_W-1:0] pb_i,
  output idx_decode_t       dec_o
);
  logic ind_bit;
  logic ext_ok;

  assign ind_bit = pb_i[7] & pb_i[4];
  assign ext_ok  = pb_i[4] & (pb_i[6:5] == 2'b00);

  always_comb begin
    dec_o          = '0;
    dec_o.mode     = MD_SHORT;
    dec_o.indirect = ind_bit;
    if (pb_i[7]) begin
      unique case (pb_i[3:0])
        4'h0: begin dec_o.mode = MD_INC1;  dec_o.autostep = 1'b1; dec_o.illegal = pb_i[4]; end
        4'h1: begin dec_o.mode = MD_INC2;  dec_o.autostep = 1'b1; end
        4'h2: begin dec_o.mode = MD_DEC1;  dec_o.autostep = 1'b1; dec_o.illegal = pb_i[4]; end
        4'h3: begin dec_o.mode = MD_DEC2;  dec_o.autostep = 1'b1; end
        4'h4: dec_o.mode = MD_ZERO;
        4'h5: dec_o.mode = MD_ACC_B;
        4'h6: dec_o.mode = MD_ACC_A;
        4'h8: begin dec_o.mode = MD_CONST8;  dec_o.nofs = CNT_W'(1); end
        4'h9: begin dec_o.mode = MD_CONST16; dec_o.nofs = CNT_W'(2); end
        4'hB: dec_o.mode = MD_ACC_D;
        4'hC: begin dec_o.mode = MD_PCREL8;  dec_o.nofs = CNT_W'(1); end
        4'hD: begin dec_o.mode = MD_PCREL16; dec_o.nofs = CNT_W'(2); end
        4'hF: begin dec_o.mode = MD_EXTIND;  dec_o.nofs = CNT_W'(2); dec_o.illegal = ~ext_ok; end
        default: dec_o.illegal = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/idx_addr_calc.sv
module idx_addr_calc
  import idx_ea_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  idx_mode_e          mode_i,
  input  logic [SHORT_W-1:0] short_i,
  input  logic [ADDR_W-1:0]  base_i,
  input  logic [ADDR_W-1:0]  pc_i,
  input  logic [BYTE_W-1:0]  acc_a_i,
  input  logic [BYTE_W-1:0]  acc_b_i,
  input  logic [ADDR_W-1:0]  ofs_i,
  output logic [ADDR_W-1:0]  ea_o,
  output logic [ADDR_W-1:0]  ptr_upd_o
);
  always_comb begin
    ea_o      = base_i;
    ptr_upd_o = base_i;
    unique case (mode_i)
      MD_SHORT:   ea_o = base_i + sext_short(short_i);
      MD_INC1:    ptr_upd_o = base_i + ADDR_W'(1);
      MD_INC2:    ptr_upd_o = base_i + ADDR_W'(2);
      MD_DEC1:    begin ea_o = base_i - ADDR_W'(1); ptr_upd_o = base_i - ADDR_W'(1); end
      MD_DEC2:    begin ea_o = base_i - ADDR_W'(2); ptr_upd_o = base_i - ADDR_W'(2); end
      MD_ZERO:    ea_o = base_i;
      MD_ACC_B:   ea_o = base_i + sext_byte(acc_b_i);
      MD_ACC_A:   ea_o = base_i + sext_byte(acc_a_i);
      MD_ACC_D:   ea_o = base_i + {acc_a_i, acc_b_i};
      MD_CONST8:  ea_o = base_i + sext_byte(ofs_i[BYTE_W-1:0]);
      MD_CONST16: ea_o = base_i + ofs_i;
      MD_PCREL8:  ea_o = pc_i + sext_byte(ofs_i[BYTE_W-1:0]);
      MD_PCREL16: ea_o = pc_i + ofs_i;
      MD_EXTIND:  ea_o = ofs_i;
      default:    ea_o = base_i;
    endcase
  end

  AST_PREDEC_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MD_DEC2) |-> (ptr_upd_o == ea_o)); // R3
  AST_POSTINC_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MD_INC1) |-> (ea_o == base_i)); // R3
endmodule

// File: rtl/idx_seq_fsm.sv
module idx_seq_fsm
  import idx_ea_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [BYTE_W-1:0] pb_i,
  input  logic              lea_en_i,
  input  logic [PSEL_W-1:0] lea_dst_i,
  input  logic [ADDR_W-1:0] ptr_x_i,
  input  logic [ADDR_W-1:0] ptr_y_i,
  input  logic [ADDR_W-1:0] ptr_u_i,
  input  logic [ADDR_W-1:0] ptr_s_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [BYTE_W-1:0] acc_a_i,
  input  logic [BYTE_W-1:0] acc_b_i,
  input  idx_decode_t       dec_i,
  input  logic [ADDR_W-1:0] ea_calc_i,
  input  logic [ADDR_W-1:0] ptr_upd_i,
  output logic [BYTE_W-1:0] pb_o,
  output logic [ADDR_W-1:0] base_o,
  output logic [ADDR_W-1:0] pc_cur_o,
  output logic [BYTE_W-1:0] acc_a_o,
  output logic [BYTE_W-1:0] acc_b_o,
  output logic [ADDR_W-1:0] ofs_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_ready_i,
  input  logic [BYTE_W-1:0] mem_rdata_i,
  output logic [ADDR_W-1:0] ea_o,
  output logic              done_o,
  output logic              illegal_o,
  output logic              ptr_we_o,
  output logic [PSEL_W-1:0] ptr_sel_o,
  output logic [ADDR_W-1:0] ptr_wdata_o,
  output logic              pc_we_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic              lea_we_o,
  output logic [PSEL_W-1:0] lea_sel_o
);
  idx_state_e        state_q, state_d;
  logic [BYTE_W-1:0] pb_q, a_q, b_q;
  logic [ADDR_W-1:0] base_q, pc_q, pc_d, ofs_q, ofs_d, ea_q, ea_d, ptr_q, ptr_d;
  logic [CNT_W-1:0]  left_q, left_d;
  logic              ill_q, ill_d, auto_q, auto_d, ind_q, ind_d;
  logic              lea_en_q;
  logic [PSEL_W-1:0] dst_q;
  logic [ADDR_W-1:0] base_sel;
  logic              cap_en, xfer, legal_done;

  assign cap_en = (state_q == ST_IDLE) & start_i;
  assign xfer   = mem_req_o & mem_ready_i;

  always_comb begin
    unique case (pb_i[6:5])
      2'b00:   base_sel = ptr_x_i;
      2'b01:   base_sel = ptr_y_i;
      2'b10:   base_sel = ptr_u_i;
      default: base_sel = ptr_s_i;
    endcase
  end

  // next-state process
  always_comb begin
    state_d = state_q;
    pc_d    = pc_q;
    ofs_d   = ofs_q;
    ea_d    = ea_q;
    ptr_d   = ptr_q;
    left_d  = left_q;
    ill_d   = ill_q;
    auto_d  = auto_q;
    ind_d   = ind_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_DECODE;
          pc_d    = pc_i;
        end
      end
      ST_DECODE: begin
        ill_d  = dec_i.illegal;
        auto_d = dec_i.autostep & ~dec_i.illegal;
        ind_d  = dec_i.indirect;
        left_d = dec_i.nofs;
        if (dec_i.illegal) begin
          state_d = ST_FIN;
        end else if (dec_i.nofs != '0) begin
          state_d = ST_FETCH;
        end else begin
          ea_d    = ea_calc_i;
          ptr_d   = ptr_upd_i;
          state_d = dec_i.indirect ? ST_IND_HI : ST_FIN;
        end
      end
      ST_FETCH: begin
        if (xfer) begin
          ofs_d  = {ofs_q[BYTE_W-1:0], mem_rdata_i};
          pc_d   = pc_q + ADDR_W'(1);
          left_d = left_q - CNT_W'(1);
          if (left_q == CNT_W'(1)) state_d = ST_ADDR;
        end
      end
      ST_ADDR: begin
        ea_d    = ea_calc_i;
        ptr_d   = ptr_upd_i;
        state_d = ind_q ? ST_IND_HI : ST_FIN;
      end
      ST_IND_HI: begin
        if (xfer) begin
          ofs_d   = {ofs_q[BYTE_W-1:0], mem_rdata_i};
          state_d = ST_IND_LO;
        end
      end
      ST_IND_LO: begin
        if (xfer) begin
          ea_d    = {ofs_q[BYTE_W-1:0], mem_rdata_i};
          state_d = ST_FIN;
        end
      end
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      pb_q     <= '0;
      base_q   <= '0;
      a_q      <= '0;
      b_q      <= '0;
      lea_en_q <= 1'b0;
      dst_q    <= '0;
      pc_q     <= '0;
      ofs_q    <= '0;
      ea_q     <= '0;
      ptr_q    <= '0;
      left_q   <= '0;
      ill_q    <= 1'b0;
      auto_q   <= 1'b0;
      ind_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (cap_en) begin
        pb_q     <= pb_i;
        base_q   <= base_sel;
        a_q      <= acc_a_i;
        b_q      <= acc_b_i;
        lea_en_q <= lea_en_i;
        dst_q    <= lea_dst_i;
      end
      pc_q   <= pc_d;
      ofs_q  <= ofs_d;
      ea_q   <= ea_d;
      ptr_q  <= ptr_d;
      left_q <= left_d;
      ill_q  <= ill_d;
      auto_q <= auto_d;
      ind_q  <= ind_d;
    end
  end

  assign pb_o     = pb_q;
  assign base_o   = base_q;
  assign pc_cur_o = pc_q;
  assign acc_a_o  = a_q;
  assign acc_b_o  = b_q;
  assign ofs_o    = ofs_q;

  assign mem_req_o  = (state_q == ST_FETCH) | (state_q == ST_IND_HI) | (state_q == ST_IND_LO);
  assign mem_addr_o = (state_q == ST_FETCH)  ? pc_q :
                      (state_q == ST_IND_HI) ? ea_q : (ea_q + ADDR_W'(1));

  assign done_o      = (state_q == ST_FIN);
  assign illegal_o   = done_o & ill_q;
  assign legal_done  = done_o & ~ill_q;
  assign ea_o        = ea_q;
  assign ptr_we_o    = legal_done & auto_q;
  assign ptr_sel_o   = pb_q[6:5];
  assign ptr_wdata_o = ptr_q;
  assign pc_we_o     = legal_done;
  assign pc_o        = pc_q;
  assign lea_we_o    = legal_done & lea_en_q;
  assign lea_sel_o   = dst_q;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R12
  AST_WRITE_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_we_o || pc_we_o || lea_we_o) |-> done_o); // R12
  AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> (!ptr_we_o && !pc_we_o && !lea_we_o)); // R9
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o))); // R10
  AST_IND_NEXT_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IND_HI && xfer) |=> (mem_addr_o == ($past(mem_addr_o) + ADDR_W'(1)))); // R7
  AST_DONE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !mem_req_o); // R10
endmodule

// File: rtl/idx_ea_seq.sv
module idx_ea_seq
  import idx_ea_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [BYTE_W-1:0] postbyte_i,
  input  logic              lea_en_i,
  input  logic [PSEL_W-1:0] lea_dst_i,
  input  logic [ADDR_W-1:0] ptr_x_i,
  input  logic [ADDR_W-1:0] ptr_y_i,
  input  logic [ADDR_W-1:0] ptr_u_i,
  input  logic [ADDR_W-1:0] ptr_s_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [BYTE_W-1:0] acc_a_i,
  input  logic [BYTE_W-1:0] acc_b_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_ready_i,
  input  logic [BYTE_W-1:0] mem_rdata_i,
  output logic [ADDR_W-1:0] ea_o,
  output logic              done_o,
  output logic              illegal_o,
  output logic              ptr_we_o,
  output logic [PSEL_W-1:0] ptr_sel_o,
  output logic [ADDR_W-1:0] ptr_wdata_o,
  output logic              pc_we_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic              lea_we_o,
  output logic [PSEL_W-1:0] lea_sel_o
);
  idx_decode_t       dec;
  logic [BYTE_W-1:0] pb_q, a_q, b_q;
  logic [ADDR_W-1:0] base_q, pc_cur, ofs_q, ea_calc, ptr_upd;

  idx_postbyte_decode u_dec (
    .pb_i  (pb_q),
    .dec_o (dec)
  );

  idx_addr_calc u_calc (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_i    (dec.mode),
    .short_i   (pb_q[SHORT_W-1:0]),
    .base_i    (base_q),
    .pc_i      (pc_cur),
    .acc_a_i   (a_q),
    .acc_b_i   (b_q),
    .ofs_i     (ofs_q),
    .ea_o      (ea_calc),
    .ptr_upd_o (ptr_upd)
  );

  idx_seq_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .pb_i        (postbyte_i),
    .lea_en_i    (lea_en_i),
    .lea_dst_i   (lea_dst_i),
    .ptr_x_i     (ptr_x_i),
    .ptr_y_i     (ptr_y_i),
    .ptr_u_i     (ptr_u_i),
    .ptr_s_i     (ptr_s_i),
    .pc_i        (pc_i),
    .acc_a_i     (acc_a_i),
    .acc_b_i     (acc_b_i),
    .dec_i       (dec),
    .ea_calc_i   (ea_calc),
    .ptr_upd_i   (ptr_upd),
    .pb_o        (pb_q),
    .base_o      (base_q),
    .pc_cur_o    (pc_cur),
    .acc_a_o     (a_q),
    .acc_b_o     (b_q),
    .ofs_o       (ofs_q),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o),
    .mem_ready_i (mem_ready_i),
    .mem_rdata_i (mem_rdata_i),
    .ea_o        (ea_o),
    .done_o      (done_o),
    .illegal_o   (illegal_o),
    .ptr_we_o    (ptr_we_o),
    .ptr_sel_o   (ptr_sel_o),
    .ptr_wdata_o (ptr_wdata_o),
    .pc_we_o     (pc_we_o),
    .pc_o        (pc_o),
    .lea_we_o    (lea_we_o),
    .lea_sel_o   (lea_sel_o)
  );
endmodule

// File: tb/idx_ea_seq_bench.sv
module idx_ea_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  pb = '0;
  logic        lea_en = 1'b0;
  logic [1:0]  lea_dst = '0;
  logic [15:0] rx = '0, ry = '0, ru = '0, rs = '0, rpc = '0;
  logic [7:0]  ra = '0, rb = '0;
  logic        mem_req, mem_ready, done, illegal, ptr_we, pc_we, lea_we;
  logic [15:0] mem_addr, ea, ptr_wdata, pcv;
  logic [7:0]  mem_rdata;
  logic [1:0]  ptr_sel, lea_sel;
  logic        stall_on = 1'b0;
  logic [2:0]  cyc = '0;
  int          nrd = 0;
  int          tests = 0;
  int          fails = 0;

  always #4 clk = ~clk;

  function automatic logic [7:0] memf(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ {a[3:0], a[7:4]} ^ 8'h3C;
  endfunction

  assign mem_rdata = memf(mem_addr);
  assign mem_ready = !stall_on || (cyc != 3'd0 && cyc != 3'd3);

  always @(posedge clk) begin
    cyc <= cyc + 3'd1;
    if (rst_n && mem_req && mem_ready) nrd <= nrd + 1;
  end

  idx_ea_seq u_idx_ea_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start), .postbyte_i(pb),
    .lea_en_i(lea_en), .lea_dst_i(lea_dst),
    .ptr_x_i(rx), .ptr_y_i(ry), .ptr_u_i(ru), .ptr_s_i(rs),
    .pc_i(rpc), .acc_a_i(ra), .acc_b_i(rb),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_ready_i(mem_ready),
    .mem_rdata_i(mem_rdata), .ea_o(ea), .done_o(done), .illegal_o(illegal),
    .ptr_we_o(ptr_we), .ptr_sel_o(ptr_sel), .ptr_wdata_o(ptr_wdata),
    .pc_we_o(pc_we), .pc_o(pcv), .lea_we_o(lea_we), .lea_sel_o(lea_sel)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp,
                     input logic [7:0] p);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s pb=%02h act=%0h exp=%0h", tag, p, act, exp);
    end
  endtask

  task automatic model(input logic [7:0] p, output bit e_ill, output logic [15:0] e_ea,
                       output logic [15:0] e_pc, output bit e_auto, output logic [15:0] e_wd,
                       output int e_nrd, output int e_lat, output string tag);
    logic [15:0] base, ofs, addr;
    logic [7:0]  b0;
    int          nofs;
    bit          ind;
    unique case (p[6:5])
      2'b00: base = rx;
      2'b01: base = ry;
      2'b10: base = ru;
      default: base = rs;
    endcase
    e_ill = 0; e_auto = 0; e_wd = base; nofs = 0; ind = 0; addr = base;
    b0 = memf(rpc); ofs = {memf(rpc), memf(rpc + 16'd1)};
    tag = "R4";
    if (!p[7]) begin
      addr = base + {{11{p[4]}}, p[4:0]}; tag = "R2";
    end else begin
      ind = p[4];
      unique case (p[3:0])
        4'h0: begin addr = base; e_auto = 1; e_wd = base + 16'd1; tag = "R3"; end
        4'h1: begin addr = base; e_auto = 1; e_wd = base + 16'd2; tag = "R3"; end
        4'h2: begin addr = base - 16'd1; e_auto = 1; e_wd = addr; tag = "R3"; end
        4'h3: begin addr = base - 16'd2; e_auto = 1; e_wd = addr; tag = "R3"; end
        4'h4: addr = base;
        4'h5: addr = base + {{8{rb[7]}}, rb};
        4'h6: addr = base + {{8{ra[7]}}, ra};
        4'hB: addr = base + {ra, rb};
        4'h8: begin nofs = 1; addr = base + {{8{b0[7]}}, b0}; tag = "R5"; end
        4'h9: begin nofs = 2; addr = base + ofs; tag = "R5"; end
        4'hC: begin nofs = 1; addr = rpc + 16'd1 + {{8{b0[7]}}, b0}; tag = "R6"; end
        4'hD: begin nofs = 2; addr = rpc + 16'd2 + ofs; tag = "R6"; end
        4'hF: begin
          tag = "R8";
          if (p[4] && p[6:5] == 2'b00) begin nofs = 2; addr = ofs; end
          else e_ill = 1;
        end
        default: e_ill = 1;
      endcase
      if (ind && (p[3:0] == 4'h0 || p[3:0] == 4'h2)) e_ill = 1;
    end
    if (ind && !e_ill) begin
      addr = {memf(addr), memf(addr + 16'd1)};
      if (tag != "R8") tag = "R7";
    end
    e_ea  = addr;
    e_pc  = rpc + 16'(nofs);
    e_nrd = e_ill ? 0 : nofs + (ind ? 2 : 0);
    e_lat = e_ill ? 2 : 2 + nofs + (nofs > 0 ? 1 : 0) + (ind ? 2 : 0);
  endtask

  task automatic run_op(input logic [7:0] p, input bit len, input logic [1:0] dst);
    bit e_ill, e_auto;
    logic [15:0] e_ea, e_pc, e_wd;
    int e_nrd, e_lat, lat, n0;
    string tag;
    model(p, e_ill, e_ea, e_pc, e_auto, e_wd, e_nrd, e_lat, tag);
    @(negedge clk);
    pb = p; lea_en = len; lea_dst = dst; start = 1'b1; n0 = nrd;
    @(negedge clk);
    start = 1'b0; lat = 1;
    while (!done && lat < 60) begin @(negedge clk); lat++; end
    chk("R12 done seen", 32'(done), 32'd1, p);
    chk("R9 illegal flag", 32'(illegal), 32'(e_ill), p);
    if (!stall_on || e_nrd == 0) chk("R10 latency", 32'(lat), 32'(e_lat), p);
    chk(e_nrd > 2 || tag == "R7" ? "R7 read count" : "R5 read count", 32'(nrd - n0), 32'(e_nrd), p);
    if (e_ill) begin
      chk("R9 pc_we", 32'(pc_we), 32'd0, p);
      chk("R9 ptr_we", 32'(ptr_we), 32'd0, p);
      chk("R9 lea_we", 32'(lea_we), 32'd0, p);
    end else begin
      chk({tag, " ea"}, 32'(ea), 32'(e_ea), p);
      chk("R5 pc_o", 32'(pcv), 32'(e_pc), p);
      chk("R5 pc_we", 32'(pc_we), 32'd1, p);
      chk("R3 ptr_we", 32'(ptr_we), 32'(e_auto), p);
      if (e_auto) begin
        chk("R1 ptr_sel", 32'(ptr_sel), 32'(p[6:5]), p);
        chk("R3 ptr_wdata", 32'(ptr_wdata), 32'(e_wd), p);
      end
      chk("R11 lea_we", 32'(lea_we), 32'(len), p);
      if (len) chk("R11 lea_sel", 32'(lea_sel), 32'(dst), p);
    end
    @(negedge clk);
    chk("R12 done pulse", 32'(done), 32'd0, p);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; tests++;
    $display("FAIL R10 watchdog act=running exp=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R12 reset done", 32'(done), 32'd0, 8'h00);
    chk("R10 reset req", 32'(mem_req), 32'd0, 8'h00);
    chk("R12 reset we", 32'({ptr_we, pc_we, lea_we}), 32'd0, 8'h00);
    rst_n = 1'b1;
    // pass 0: positive accumulators, ready always high
    rx = 16'h1234; ry = 16'h2000; ru = 16'h4F00; rs = 16'h7FF0;
    rpc = 16'h0100; ra = 8'h12; rb = 8'h34; stall_on = 1'b0;
    for (int i = 0; i < 256; i++) run_op(8'(i), 1'b1, 2'(i ^ (i >> 3)));
    // pass 1: negative accumulators, pc near wrap, stalls
    rx = 16'h0003; ry = 16'hFFFF; ru = 16'h8001; rs = 16'h0000;
    rpc = 16'hFFFE; ra = 8'hF0; rb = 8'h81; stall_on = 1'b1;
    for (int i = 0; i < 256; i++) run_op(8'(i), 1'b0, 2'd0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule